// File: doc/BRIEF.md
# DRAM Pattern-Register Read Path

This block models the read data path of a double-data-rate memory device in which a small built-in pattern source can stand in for the memory core. A three-bit mode-register field chooses where read data comes from. With its enable bit clear, reads return words from a stubbed memory array and writes update that array. With the enable bit set, each READ returns a fixed 8-bit pattern serialized one bit per beat. The bit is driven on the prime data lanes and every other lane is held low, while writes leave the array untouched.

Bursts of eight beats and chopped bursts of four are supported. The burst length is either fixed by a configuration input or chosen per command by a chop control bit. Column address bit 2 selects the nibble in chopped bursts. Data leaves a parameterized number of cycles (CL) after the command, one beat per clock, and is framed by a data-valid flag. A sticky flag records pattern reads that were issued with an illegal column address.

Top module: `mpr_read_path`

## Requirements
- R1: After reset the pattern source is disabled, `dq_valid` is 0, `dq` is all zero and `addr_err` is 0.
- R2: With `mr_data[2]` = 0 loaded, a write stores `wr_data` at word `cmd_col`. Beat k of a read returns the array word at (`cmd_col` with bits [2:0] cleared) + burst index. `mr_data[1:0]` has no effect.
- R3: With `mr_data[2]` = 1 loaded, writes leave the array unchanged. Each read beat drives its pattern bit on lane 0 (and also on lane 8 when DQ_W = 16), and all other lanes are 0.
- R4: Pattern select `mr_data[1:0]` = 00 gives the pattern 8'hAA. Every other select value gives 8'h00. The pattern is captured when the READ is accepted.
- R5: A full burst emits burst indices 0 to 7 in order, and beat index i carries pattern bit i (bit 0 first, bit 7 last).
- R6: A chopped burst emits indices 0 to 3 when `cmd_col[2]` = 0 and indices 4 to 7 when `cmd_col[2]` = 1.
- R7: `burst_cfg` encoding: 00 gives a fixed burst of eight, 10 a fixed chop of four, and 01 selects per command (`cmd_bc_n` = 0 chops, 1 gives eight). The value 11 acts as 00.
- R8: The first beat is visible just after the CL-th rising edge following the edge that samples the READ. `dq_valid` is then high for exactly 4 or 8 consecutive cycles.
- R9: A pattern-mode READ with `cmd_col[1:0]` ≠ 00, or with `cmd_col[2]` = 1 in a full burst, sets `addr_err` from the next edge until reset. The burst still runs, starting at index 0 for full bursts. Array-mode reads never set it.
- R10: A READ sampled while a burst is still being issued is ignored, and `dq` is all zero whenever `dq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_load | input | 1 | Load `mr_data` into the pattern mode register |
| mr_data | input | 3 | [2] pattern enable, [1:0] pattern select |
| burst_cfg | input | 2 | Burst length configuration (R7) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Column (word) address |
| cmd_bc_n | input | 1 | Per-command chop control, low = chop |
| wr_data | input | DQ_W | Write data word |
| dq | output | DQ_W | Read data lanes |
| dq_valid | output | 1 | Read beat present on `dq` |
| addr_err | output | 1 | Sticky illegal pattern-read address flag |

## Verification
On every cycle the assertions check these properties: idle lanes stay quiet, pattern beats touch only the prime lanes, both prime lanes match on the 16-lane variant, the error flag never clears, and every valid run lasts 4 or 8 beats. Which pattern bit or array word lands in which beat, the exact CL offset, nibble selection, the three burst configurations, ignored writes and ignored overlapping reads all depend on earlier commands. Only the bench's reference model, comparing each cycle, can show those.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [1:0] {
        BCFG_FIX8 = 2'b00,
        BCFG_OTF  = 2'b01,
        BCFG_FIX4 = 2'b10,
        BCFG_RSVD = 2'b11
    } burst_cfg_e;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } mr_pat_t;

    localparam logic [7:0] PAT_TRAIN = 8'hAA;

    function automatic logic [7:0] pattern_of(input logic [1:0] sel);
        return (sel == 2'b00) ? PAT_TRAIN : 8'h00;
    endfunction

endpackage

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg
    import mpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] data,
    output mr_pat_t    mr
);
    mr_pat_t mr_d, mr_q;

    always_comb begin
        mr_d = mr_q;
        if (load) begin
            mr_d.en  = data[2];
            mr_d.sel = data[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mr_q <= '0;
        else        mr_q <= mr_d;
    end

    assign mr = mr_q;
endmodule

// File: rtl/mpr_array_stub.sv
module mpr_array_stub #(
    parameter int DQ_W  = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DQ_W-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DQ_W-1:0] rdata
);
    logic [DEPTH-1:0][DQ_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
    import mpr_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic [COL_W-1:0] col,
    input  logic             bc_n,
    input  logic [1:0]       cfg,
    input  mr_pat_t          mr,
    output logic [COL_W-1:0] arr_raddr,
    output logic             beat_valid,
    output logic             beat_src_pat,
    output logic             beat_bit,
    output logic             err
);
    typedef struct packed {
        logic             active;
        logic [2:0]       idx;
        logic [3:0]       left;
        logic             src_pat;
        logic [7:0]       pat;
        logic [COL_W-1:0] base;
        logic             err;
    } seq_t;

    seq_t       s_d, s_q;
    burst_cfg_e cfg_e;
    logic       chop;
    logic       nib;
    logic       bad_addr;

    always_comb begin
        cfg_e    = burst_cfg_e'(cfg);
        chop     = (cfg_e == BCFG_FIX4) || ((cfg_e == BCFG_OTF) && !bc_n);
        nib      = chop & col[2];
        bad_addr = (col[1:0] != 2'b00) || (!chop && col[2]);
        s_d      = s_q;
        if (s_q.active) begin
            s_d.idx  = s_q.idx + 3'd1;
            s_d.left = s_q.left - 4'd1;
            if (s_q.left == 4'd1) s_d.active = 1'b0;
        end else if (rd_go) begin
            s_d.active  = 1'b1;
            s_d.left    = chop ? 4'd4 : 4'd8;
            s_d.idx     = {nib, 2'b00};
            s_d.src_pat = mr.en;
            s_d.pat     = pattern_of(mr.sel);
            s_d.base    = {col[COL_W-1:3], 3'b000};
            if (mr.en && bad_addr) s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arr_raddr    = s_q.base | COL_W'(s_q.idx);
    assign beat_valid   = s_q.active;
    assign beat_src_pat = s_q.src_pat;
    assign beat_bit     = s_q.pat[s_q.idx];
    assign err          = s_q.err;
endmodule

// File: rtl/mpr_lane_drive.sv
module mpr_lane_drive #(
    parameter int DQ_W = 16
) (
    input  logic            valid,
    input  logic            src_pat,
    input  logic            pbit,
    input  logic [DQ_W-1:0] word,
    output logic [DQ_W-1:0] lanes
);
    for (genvar i = 0; i < DQ_W; i++) begin : g_lane
        localparam bit PRIME = (i == 0) || (DQ_W == 16 && i == 8);
        if (PRIME) begin : g_prime
            assign lanes[i] = valid & (src_pat ? pbit : word[i]);
        end else begin : g_other
            assign lanes[i] = valid & ~src_pat & word[i];
        end
    end
endmodule

// File: rtl/mpr_latency_pipe.sv
module mpr_latency_pipe #(
    parameter int W  = 18,
    parameter int CL = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [CL-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < CL; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[CL-1];
endmodule

// File: rtl/mpr_read_path.sv
module mpr_read_path
    import mpr_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int DEPTH  = 64,
    parameter int CL     = 5,
    localparam int COL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr_load,
    input  logic [2:0]       mr_data,
    input  logic [1:0]       burst_cfg,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_bc_n,
    input  logic [DQ_W-1:0]  wr_data,
    output logic [DQ_W-1:0]  dq,
    output logic             dq_valid,
    output logic             addr_err
);
    localparam int PW = DQ_W + 2;

    mr_pat_t          mr;
    logic [COL_W-1:0] raddr;
    logic [DQ_W-1:0]  rword;
    logic [DQ_W-1:0]  lanes;
    logic             bvalid, bsrc, bbit;
    logic [PW-1:0]    pipe_out;
    logic             out_src_pat;

    mpr_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .load(mr_load), .data(mr_data), .mr(mr)
    );

    mpr_array_stub #(.DQ_W(DQ_W), .DEPTH(DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we(cmd_valid & cmd_write & ~mr.en),
        .waddr(cmd_col), .wdata(wr_data),
        .raddr(raddr), .rdata(rword)
    );

    mpr_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rd_go(cmd_valid & ~cmd_write),
        .col(cmd_col), .bc_n(cmd_bc_n), .cfg(burst_cfg), .mr(mr),
        .arr_raddr(raddr), .beat_valid(bvalid), .beat_src_pat(bsrc),
        .beat_bit(bbit), .err(addr_err)
    );

    mpr_lane_drive #(.DQ_W(DQ_W)) u_lanes (
        .valid(bvalid), .src_pat(bsrc), .pbit(bbit), .word(rword), .lanes(lanes)
    );

    mpr_latency_pipe #(.W(PW), .CL(CL)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .din({bvalid, bsrc, lanes}),
        .dout(pipe_out)
    );

    assign dq_valid    = pipe_out[PW-1];
    assign out_src_pat = pipe_out[PW-2];
    assign dq          = pipe_out[DQ_W-1:0];
endmodule

// File: rtl/mpr_read_path_chk.sv
module mpr_read_path_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DQ_W-1:0] dq,
    input logic            dq_valid,
    input logic            out_src_pat,
    input logic            addr_err
);
    localparam logic [DQ_W-1:0] PRIME_MASK =
        (DQ_W == 16) ? DQ_W'(16'h0101) : DQ_W'(1);

    logic [3:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (dq_valid) run_q <= (run_q == 4'hF) ? run_q : run_q + 4'd1;
        else               run_q <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> dq == '0); // R10

    AST_PAT_PRIME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && out_src_pat) |-> (dq & ~PRIME_MASK) == '0); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err); // R9

    AST_BURST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_valid) |-> (run_q == 4'd4 || run_q == 4'd8)); // R8

    if (DQ_W == 16) begin : g_x16
        AST_X16_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_valid && out_src_pat) |-> dq[8] == dq[0]); // R3
    end
endmodule

bind mpr_read_path mpr_read_path_chk #(.DQ_W(DQ_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .dq(dq), .dq_valid(dq_valid),
    .out_src_pat(out_src_pat), .addr_err(addr_err)
);

// File: tb/test_mpr_read_path.sv
module test_mpr_read_path;
    localparam int DQ_W  = 16;
    localparam int DEPTH = 64;
    localparam int CL    = 5;
    localparam int COL_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mr_load = 1'b0;
    logic [2:0]       mr_data = '0;
    logic [1:0]       burst_cfg = 2'b00;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_bc_n = 1'b1;
    logic [DQ_W-1:0]  wr_data = '0;
    logic [DQ_W-1:0]  dq;
    logic             dq_valid;
    logic             addr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    mpr_read_path #(.DQ_W(DQ_W), .DEPTH(DEPTH), .CL(CL)) i_mpr_read_path (
        .clk(clk), .rst_n(rst_n), .mr_load(mr_load), .mr_data(mr_data),
        .burst_cfg(burst_cfg), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_bc_n(cmd_bc_n), .wr_data(wr_data),
        .dq(dq), .dq_valid(dq_valid), .addr_err(addr_err)
    );

    always #4 clk = ~clk;

    // reference model
    int              cyc = 0;
    int              busy_until = -1;
    bit              m_en = 0;
    logic [1:0]      m_sel = '0;
    bit              m_err = 0;
    logic [DQ_W-1:0] m_mem [DEPTH];
    bit              exp_v [int];
    logic [DQ_W-1:0] exp_d [int];
    string           exp_r [int];

    function automatic logic [DQ_W-1:0] prime_word(input bit b);
        logic [DQ_W-1:0] w = '0;
        if (b) begin
            w[0] = 1'b1;
            if (DQ_W == 16) w[8 % DQ_W] = 1'b1;
        end
        return w;
    endfunction

    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (cmd_valid && !cmd_write && cyc > busy_until) begin
                bit chop;
                int n, start, base;
                chop = (burst_cfg == 2'b10) || (burst_cfg == 2'b01 && !cmd_bc_n);
                n = chop ? 4 : 8;
                busy_until = cyc + n;
                start = (chop && cmd_col[2]) ? 4 : 0;
                base = int'(cmd_col) / 8 * 8;
                for (int k = 0; k < n; k++) begin
                    int idx;
                    logic [7:0] pat;
                    idx = start + k;
                    pat = (m_sel == 2'b00) ? 8'hAA : 8'h00;
                    exp_v[cyc + CL + k] = 1'b1;
                    exp_d[cyc + CL + k] = m_en ? prime_word(pat[idx]) : m_mem[base + idx];
                    exp_r[cyc + CL + k] = m_en ? (chop ? "R3/R4/R6" : "R3/R4/R5")
                                               : (chop ? "R2/R6" : "R2/R5");
                end
                if (m_en && (cmd_col[1:0] != 2'b00 || (!chop && cmd_col[2]))) m_err = 1;
            end
            if (cmd_valid && cmd_write && !m_en) m_mem[cmd_col] = wr_data;
            if (mr_load) begin
                m_en  = mr_data[2];
                m_sel = mr_data[1:0];
            end
        end
        cyc = cyc + 1;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int key;
            bit ev;
            logic [DQ_W-1:0] ed;
            string rq;
            key = cyc - 1;
            ev = exp_v.exists(key) ? exp_v[key] : 1'b0;
            ed = exp_d.exists(key) ? exp_d[key] : '0;
            rq = exp_r.exists(key) ? exp_r[key] : "R10";
            n_cmp++;
            if (dq_valid !== ev || dq !== ed) begin
                n_bad++;
                $display("FAIL %s (R8 timing) cycle %0d: valid=%0b dq=%h expected valid=%0b dq=%h",
                         rq, key, dq_valid, dq, ev, ed);
            end
            n_cmp++;
            if (addr_err !== m_err) begin
                n_bad++;
                $display("FAIL R9 cycle %0d: addr_err=%0b expected %0b", key, addr_err, m_err);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mrs(input logic [2:0] v);
        @(negedge clk);
        mr_load = 1'b1; mr_data = v;
        @(negedge clk);
        mr_load = 1'b0;
    endtask

    task automatic wr(input int col, input logic [DQ_W-1:0] v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = COL_W'(col); wr_data = v;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
    endtask

    task automatic rd(input int col, input bit bc_n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = COL_W'(col); cmd_bc_n = bc_n;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_bc_n = 1'b1;
    endtask

    initial begin
        idle(3);
        // R1: reset state
        n_cmp++;
        if (dq !== '0 || dq_valid !== 1'b0 || addr_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: dq=%h valid=%0b err=%0b expected 0/0/0", dq, dq_valid, addr_err);
        end
        rst_n = 1'b1;
        idle(2);

        // R2: array mode, writes then reads
        for (int i = 0; i < 16; i++) wr(i, DQ_W'(16'h1000 + i * 16'h0111));
        burst_cfg = 2'b00; rd(0, 1); idle(16);           // R5 full burst
        burst_cfg = 2'b10; rd(12, 1); idle(16);          // R6 upper nibble
        rd(9, 1); idle(16);                              // R6 lower nibble
        mrs(3'b011);                                     // R2 select ignored
        burst_cfg = 2'b11; rd(8, 1); idle(16);           // R7 reserved acts as 8
        rd(13, 1); idle(16);                             // R9 no error in array mode

        // R3/R4: pattern mode
        mrs(3'b100);
        wr(0, 16'hFFFF);                                 // R3 write ignored
        burst_cfg = 2'b00; rd(0, 1); idle(16);
        burst_cfg = 2'b01; rd(4, 0); idle(16);           // R7 per-command chop
        rd(0, 0); idle(16);
        rd(0, 1); idle(16);                              // R7 per-command full
        mrs(3'b101); rd(0, 1); idle(16);                 // R4 zero pattern
        mrs(3'b110); burst_cfg = 2'b10; rd(4, 1); idle(16);

        // R10: overlapping read ignored
        mrs(3'b100); burst_cfg = 2'b00;
        rd(0, 1); idle(1); rd(0, 1); idle(16);
        // R4: pattern captured at issue even if mode changes mid-burst
        rd(0, 1); mrs(3'b000); idle(16);
        burst_cfg = 2'b10; rd(0, 1); rd(4, 1); idle(16); // R10 back-to-back chop
        burst_cfg = 2'b00; rd(0, 1); idle(16);           // R3 array kept old data

        // R9: illegal pattern address
        mrs(3'b100);
        rd(2, 1); idle(16);
        rd(4, 1); idle(16);
        burst_cfg = 2'b10; rd(5, 1); idle(16);
        mrs(3'b000); rd(0, 1); idle(16);                 // R9 flag stays set

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected end before 20000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule